// File: doc/BRIEF.md
# Multiprocessor Interrupt Mask and Router

This block collects interrupt requests for a small shared-memory multiprocessor with up to four CPUs and fifteen usable priority levels (1 to 15, with 0 meaning "nothing pending"). Each CPU owns a pending register that software modifies only through a write-one-to-set port and a write-one-to-clear port. Each CPU has a hardware half and a software (inter-processor) half in that register. A shared master section shows the live system interrupt sources, holds a mask over them, and holds a target register that names the one CPU receiving those undirected system interrupts.

For every CPU the block registers the highest pending level. The candidates are the CPU's own hardware bits, its own software bits and, only for the current target CPU, the unmasked system sources. Each system source is translated to a fixed level by an internal table. The mask uses inverted sense: a set bit disables its source, and a set top bit disables all system sources at once.

Top module: `irq_router`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF, every CPU pending register reads 0, the target reads 0 and every CPU level output is 0.
- R2: A write to CPU c's set register (address 4c+2) sets each pending bit written as 1 and leaves bits written as 0 unchanged. Hardware level n is bit n and software level n is bit 16+n.
- R3: A write to CPU c's clear register (address 4c+1) clears each pending bit written as 1 and leaves bits written as 0 unchanged.
- R4: Writing 1s to the mask-clear address 18 clears those mask bits (enabling the sources). Writing 1s to the mask-set address 19 sets them (disabling the sources). Zero bits have no effect and the mask reads back at address 17.
- R5: While mask bit 31 is set, no system source contributes to any CPU level.
- R6: The target register at address 20 reads back the last in-range value written. A write of a value of NCPU or more is ignored.
- R7: Each CPU level output is the highest level n in 1..15 for which hardware bit n or software bit 16+n of that CPU is pending. For the target CPU, the levels of pending unmasked system sources also count. The output updates on the clock edge that registers the write or samples the sources.
- R8: System source bits map to levels as follows: 30, 29 and 28 to 15; 22 and 21 to 11; 20 to 8; 19 to 10; 18 to 4; 17 to 13; 16 to 6; 15 and 14 to 12; bit x+7 to level x+1 for x in 0..6. All other bits have no level.
- R9: A CPU that is not the target is not affected by system sources.
- R10: The set and clear addresses read as 0, and address 16 reads the live system source vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read register index |
| rd_data | output | 32 | Read data (combinational from the stored state) |
| sys_irq | input | 32 | Live system interrupt sources |
| irq_level | output | 4*NCPU | Per-CPU highest pending level, CPU c in bits 4c+3..4c |

## Verification
Directed writes first isolate each path. Hardware bits alone and software bits alone show which half wins. Two system sources of different level, with only one unmasked, tell the mask sense and the table apart. A target move shows whether system sources follow the chosen CPU or leak to others, and the mask-all bit is toggled with other unmasked sources present. Random writes to every address, including out-of-range target values and read-only addresses, are mixed with random source vectors. These are compared against a reference model on every level and readable register, which exposes wrong priority order and stray bit effects.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int unsigned DW        = 32;
    localparam int unsigned LVLW      = 4;
    localparam int unsigned NLVL      = 16;
    localparam int unsigned SOFT_OFS  = 16;
    localparam int unsigned GLOBAL_OFF_BIT = 31;

    typedef enum logic [1:0] {
        CR_PEND = 2'd0,
        CR_CLR  = 2'd1,
        CR_SET  = 2'd2
    } cpu_reg_e;

    typedef enum logic [2:0] {
        MR_SRC  = 3'd0,
        MR_MASK = 3'd1,
        MR_CLR  = 3'd2,
        MR_SET  = 3'd3,
        MR_TGT  = 3'd4
    } mst_reg_e;

    // level assigned to each system source bit; 0 means unused
    function automatic logic [LVLW-1:0] src_level(int b);
        logic [LVLW-1:0] l;
        case (b)
            30, 29, 28: l = 4'd15;
            22, 21:     l = 4'd11;
            20:         l = 4'd8;
            19:         l = 4'd10;
            18:         l = 4'd4;
            17:         l = 4'd13;
            16:         l = 4'd6;
            15, 14:     l = 4'd12;
            default: begin
                if (b >= 7 && b <= 13) l = LVLW'(b - 6);
                else                   l = '0;
            end
        endcase
        return l;
    endfunction
endpackage

// File: rtl/irq_src_levels.sv
module irq_src_levels
    import irq_router_pkg::*;
(
    input  logic [DW-1:0]   active,
    output logic [NLVL-1:0] lvl_vec
);
    always_comb begin
        lvl_vec = '0;
        for (int b = 0; b < int'(DW); b++) begin
            if (active[b] && src_level(b) != '0) lvl_vec[src_level(b)] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_router_pkg::*;
(
    input  logic [NLVL-1:0] vec,
    output logic [LVLW-1:0] lvl
);
    always_comb begin
        lvl = '0;
        for (int i = 1; i < int'(NLVL); i++) begin
            if (vec[i]) lvl = LVLW'(i);
        end
    end
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int unsigned NCPU = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [4:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [4:0]           rd_addr,
    output logic [31:0]          rd_data,
    input  logic [31:0]          sys_irq,
    output logic [NCPU*4-1:0]    irq_level
);
    localparam int unsigned TW = (NCPU > 1) ? $clog2(NCPU) : 1;

    typedef struct packed {
        logic [NCPU-1:0][DW-1:0] pend;
        logic [DW-1:0]           mask;
        logic [TW-1:0]           tgt;
    } regs_t;

    typedef struct packed {
        regs_t                     r;
        logic [NCPU-1:0][LVLW-1:0] lvl;
    } state_t;

    state_t st_d, st_q;
    regs_t  regs_d;
    logic [NCPU-1:0][LVLW-1:0] lvl_d;
    logic [DW-1:0]   sys_act;
    logic [NLVL-1:0] sys_vec;

    // next register values from the write port
    always_comb begin
        regs_d = st_q.r;
        if (wr_en) begin
            if (!wr_addr[4]) begin
                for (int c = 0; c < int'(NCPU); c++) begin
                    if (wr_addr[3:2] == 2'(c)) begin
                        case (cpu_reg_e'(wr_addr[1:0]))
                            CR_CLR:  regs_d.pend[c] = st_q.r.pend[c] & ~wr_data;
                            CR_SET:  regs_d.pend[c] = st_q.r.pend[c] | wr_data;
                            default: ;
                        endcase
                    end
                end
            end else if (!wr_addr[3]) begin
                case (mst_reg_e'(wr_addr[2:0]))
                    MR_CLR: regs_d.mask = st_q.r.mask & ~wr_data;
                    MR_SET: regs_d.mask = st_q.r.mask | wr_data;
                    MR_TGT: if (wr_data < 32'(NCPU)) regs_d.tgt = TW'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    assign sys_act = regs_d.mask[GLOBAL_OFF_BIT] ? '0 : (sys_irq & ~regs_d.mask);

    irq_src_levels u_src (
        .active  (sys_act),
        .lvl_vec (sys_vec)
    );

    for (genvar c = 0; c < int'(NCPU); c++) begin : g_cpu
        logic [NLVL-1:0] cand;
        assign cand = regs_d.pend[c][NLVL-1:0]
                    | regs_d.pend[c][SOFT_OFS +: NLVL]
                    | ((regs_d.tgt == TW'(c)) ? sys_vec : '0);
        irq_prio_enc u_enc (
            .vec (cand),
            .lvl (lvl_d[c])
        );
    end

    always_comb begin
        st_d.r   = regs_d;
        st_d.lvl = lvl_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.r.pend <= '0;
            st_q.r.mask <= '1;
            st_q.r.tgt  <= '0;
            st_q.lvl    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (!rd_addr[4]) begin
            for (int c = 0; c < int'(NCPU); c++) begin
                if (rd_addr[3:2] == 2'(c) && cpu_reg_e'(rd_addr[1:0]) == CR_PEND)
                    rd_data = st_q.r.pend[c];
            end
        end else if (!rd_addr[3]) begin
            case (mst_reg_e'(rd_addr[2:0]))
                MR_SRC:  rd_data = sys_irq;
                MR_MASK: rd_data = st_q.r.mask;
                MR_TGT:  rd_data = 32'(st_q.r.tgt);
                default: ;
            endcase
        end
    end

    assign irq_level = st_q.lvl;

    // flat views for the checker
    logic [NCPU*DW-1:0] pend_flat;
    logic [DW-1:0]      mask_q;
    logic [TW-1:0]      tgt_q;
    assign pend_flat = st_q.r.pend;
    assign mask_q    = st_q.r.mask;
    assign tgt_q     = st_q.r.tgt;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int unsigned NCPU = 4,
    parameter int unsigned TW   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [4:0]          wr_addr,
    input logic [31:0]         wr_data,
    input logic [NCPU*32-1:0]  pend_flat,
    input logic [31:0]         mask_q,
    input logic [TW-1:0]       tgt_q,
    input logic [NCPU*4-1:0]   irq_level
);
    // R4: mask set port
    a_r4_mask_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 5'd19) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));
    // R4: mask clear port
    a_r4_mask_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 5'd18) |=> ((mask_q & $past(wr_data)) == 32'd0));
    // R6: out-of-range target write ignored
    a_r6_bad_target: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 5'd20 && wr_data >= 32'(NCPU)) |=> $stable(tgt_q));
    a_r6_target_range: assert property (@(posedge clk) disable iff (rst)
        32'(tgt_q) < 32'(NCPU));

    for (genvar c = 0; c < int'(NCPU); c++) begin : g_c
        // R2: set port
        a_r2_set: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == 5'(4*c+2)) |=>
            ((pend_flat[c*32 +: 32] & $past(wr_data)) == $past(wr_data)));
        // R3: clear port
        a_r3_clr: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == 5'(4*c+1)) |=>
            ((pend_flat[c*32 +: 32] & $past(wr_data)) == 32'd0));
        // R5: global mask silences system sources
        a_r5_mask_all: assert property (@(posedge clk) disable iff (rst)
            (mask_q[31] && pend_flat[c*32+1 +: 15] == 15'd0 && pend_flat[c*32+17 +: 15] == 15'd0)
            |-> (irq_level[c*4 +: 4] == 4'd0));
        // R9: non-target CPUs see no system sources
        a_r9_non_target: assert property (@(posedge clk) disable iff (rst)
            (tgt_q != TW'(c) && pend_flat[c*32+1 +: 15] == 15'd0 && pend_flat[c*32+17 +: 15] == 15'd0)
            |-> (irq_level[c*4 +: 4] == 4'd0));
    end
endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU), .TW(TW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pend_flat (pend_flat),
    .mask_q    (mask_q),
    .tgt_q     (tgt_q),
    .irq_level (irq_level)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
    localparam int NCPU = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              wr_en;
    logic [4:0]        wr_addr;
    logic [31:0]       wr_data;
    logic [4:0]        rd_addr;
    logic [31:0]       rd_data;
    logic [31:0]       sys_irq;
    logic [NCPU*4-1:0] irq_level;

    irq_router #(.NCPU(NCPU)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sys_irq(sys_irq), .irq_level(irq_level)
    );

    logic [31:0] m_pend [NCPU];
    logic [31:0] m_mask;
    int          m_tgt;
    int          checks = 0;
    int          fails  = 0;

    function automatic int tbl(int b);
        if (b >= 28 && b <= 30) return 15;
        if (b == 22 || b == 21) return 11;
        if (b == 20) return 8;
        if (b == 19) return 10;
        if (b == 18) return 4;
        if (b == 17) return 13;
        if (b == 16) return 6;
        if (b == 15 || b == 14) return 12;
        if (b >= 7 && b <= 13) return b - 6;
        return 0;
    endfunction

    function automatic int exp_lvl(int c);
        int best = 0;
        for (int n = 1; n < 16; n++)
            if (m_pend[c][n] || m_pend[c][16+n]) best = n;
        if (m_tgt == c && !m_mask[31])
            for (int b = 0; b < 32; b++)
                if (sys_irq[b] && !m_mask[b] && tbl(b) > best) best = tbl(b);
        return best;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        for (int c = 0; c < NCPU; c++) chk(req, 32'(irq_level[c*4 +: 4]), 32'(exp_lvl(c)));
        for (int c = 0; c < NCPU; c++) begin
            rd(5'(4*c), d);
            chk(req, d, m_pend[c]);
        end
        rd(5'd17, d); chk(req, d, m_mask);
        rd(5'd20, d); chk(req, d, 32'(m_tgt));
    endtask

    task automatic do_wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 5'd16) begin
            if (a[1:0] == 2'd1) m_pend[a[3:2]] &= ~d;
            if (a[1:0] == 2'd2) m_pend[a[3:2]] |= d;
        end else if (a == 5'd18) m_mask &= ~d;
        else if (a == 5'd19) m_mask |= d;
        else if (a == 5'd20 && d < 32'(NCPU)) m_tgt = int'(d);
    endtask

    task automatic set_sys(logic [31:0] v);
        @(negedge clk);
        sys_irq = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; sys_irq = '0;
        for (int c = 0; c < NCPU; c++) m_pend[c] = '0;
        m_mask = 32'hFFFF_FFFF; m_tgt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R2: hard 5 and soft 2 on CPU0
        do_wr(5'd2, 32'h0004_0020);
        check_all("R2");
        chk("R2", 32'(irq_level[3:0]), 32'd5);
        do_wr(5'd2, 32'h0000_0100);
        rd(5'd0, d); chk("R2", d, 32'h0004_0120);
        // R3: clear only level 8
        do_wr(5'd1, 32'h0000_0100);
        rd(5'd0, d); chk("R3", d, 32'h0004_0020);
        // R7: soft 9 beats hard 3 on CPU1
        do_wr(5'd6, 32'h0200_0008);
        chk("R7", 32'(irq_level[7:4]), 32'd9);
        // R10: write-only regs read zero; source view is live
        rd(5'd1, d); chk("R10", d, 32'd0);
        rd(5'd19, d); chk("R10", d, 32'd0);
        set_sys(32'h0001_8000);
        rd(5'd16, d); chk("R10", d, 32'h0001_8000);
        // R4/R8: unmask serial only
        do_wr(5'd18, 32'h0000_8000);
        rd(5'd17, d); chk("R4", d, 32'hFFFF_7FFF);
        check_all("R4");
        chk("R5", 32'(irq_level[3:0]), 32'd5);
        do_wr(5'd18, 32'h8000_0000);
        chk("R8", 32'(irq_level[3:0]), 32'd12);
        chk("R9", 32'(irq_level[7:4]), 32'd9);
        // R6: move target to CPU1, then bad write
        do_wr(5'd20, 32'd1);
        chk("R6", 32'(irq_level[7:4]), 32'd12);
        chk("R9", 32'(irq_level[3:0]), 32'd5);
        do_wr(5'd20, 32'd9);
        rd(5'd20, d); chk("R6", d, 32'd1);
        // R5: global mask
        do_wr(5'd19, 32'h8000_0000);
        chk("R5", 32'(irq_level[7:4]), 32'd9);
        do_wr(5'd18, 32'h8001_0000);
        chk("R8", 32'(irq_level[7:4]), 32'd12);
        set_sys(32'h0002_0000);
        chk("R8", 32'(irq_level[7:4]), 32'd9);
        do_wr(5'd18, 32'h0002_0000);
        chk("R8", 32'(irq_level[7:4]), 32'd13);
        check_all("R8");

        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom % 4);
            if (op == 0) do_wr(5'(4 * ($urandom % 4) + 1 + ($urandom % 2)), $urandom);
            else if (op == 1) do_wr(5'(16 + ($urandom % 5)), $urandom & ($urandom | 32'h7FFF_FFFF));
            else if (op == 2) do_wr(5'd20, $urandom % 6);
            else set_sys($urandom);
            check_all("R7");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule